// File: doc/BRIEF.md
# Framed-ALOHA Reply Slot Picker

This block decides when a passive tag answers the reader during an identification round. At the start of each frame the reader announces a frame size of 2^k slots; the block draws a pseudo-random slot number from a 20-bit linear feedback shift register and counts slot boundaries down to that slot. Slot boundaries come only from advance pulses that the reader sends, so the reader can cut an empty slot short and spend no fixed time on it. When the tag's slot arrives, the block raises a one-cycle transmit strobe that the controller uses to send the reply.

Acknowledgements follow the data by one slot: the reader's verdict on a reply sent in slot K is accepted only in slot K+1. The block reports ACK, NAK or timeout to the controller. After an ACK the tag counts as identified and stays silent until reset. After a NAK or a timeout it waits for the next frame and draws a fresh slot there. Tag-count estimation and the choice of frame size belong to the reader.

Top module: `aloha_slot_picker`

## Requirements
- R1: The generator is a 20-bit shift register that steps as next = {v[18:0], v[19] ^ v[16]} (polynomial x^20 + x^17 + 1). Reset loads seed_i, or the value 1 when seed_i is zero. It steps exactly once per slot draw and at no other time.
- R2: A frame start (frame_start_i high) draws slot = (generator value before the step) AND (2^k - 1), with k = frame_log2_i. Any k above 16 is treated as 16.
- R3: For a drawn slot s > 0, tx_now_o is high in the cycle after the s-th slot_adv_i pulse that follows the frame start, and at no earlier time.
- R4: For a drawn slot of 0, tx_now_o is high in the cycle after the frame start.
- R5: tx_now_o is high for one cycle per transmission.
- R6: ack_i and nak_i are ignored in the transmit slot. After the next slot_adv_i, ack_i gives a one-cycle res_valid_o with res_code_o = 0 (ACK) in the following cycle. ack_i has priority over nak_i.
- R7: nak_i in the acknowledge slot gives res_valid_o with res_code_o = 1 (NAK) in the following cycle.
- R8: A slot_adv_i in the acknowledge slot with neither ack_i nor nak_i gives res_valid_o with res_code_o = 2 (timeout) in the following cycle.
- R9: After an ACK the block ignores frame starts and slot pulses until reset: tx_now_o and res_valid_o stay low and the generator does not step.
- R10: After a NAK or timeout, the next frame start draws a new slot as in R2 to R4.
- R11: A frame start during the countdown abandons the old slot and draws a new one. A frame start in the transmit or acknowledge slot also reports a timeout (code 2) in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_i | input | 20 | Generator seed (low ID bits), loaded at reset |
| frame_start_i | input | 1 | Frame start pulse from the command decoder |
| frame_log2_i | input | 5 | Frame size exponent k, frame has 2^k slots |
| slot_adv_i | input | 1 | Slot boundary pulse from the reader clock |
| ack_i | input | 1 | Positive acknowledge received |
| nak_i | input | 1 | Negative acknowledge received |
| tx_now_o | output | 1 | One-cycle strobe: transmit the reply now |
| res_valid_o | output | 1 | One-cycle strobe: res_code_o is valid |
| res_code_o | output | 2 | Result: 0 ACK, 1 NAK, 2 timeout |

## Verification
The hardest cases to reach are those where the reader's actions collide with the tag's own slot: an acknowledge that arrives early in the transmit slot, and a new frame that starts while the tag is still waiting for its verdict. The stimulus picks seeds, frame exponents and the outcome of each slot at random from a fixed seed. It injects early acknowledges and mid-countdown frame restarts on purpose, and it keeps its own copy of the generator sequence so that the slot of every draw is known in advance. Directed corner cases cover a zero seed, an exponent above 16 and the silence after an ACK.

// File: rtl/aloha_pkg.sv
package aloha_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_COUNT  = 3'd1,
        ST_TXSLOT = 3'd2,
        ST_ACKWIN = 3'd3,
        ST_DONE   = 3'd4
    } slot_state_e;

    typedef enum logic [1:0] {
        RES_ACK     = 2'd0,
        RES_NAK     = 2'd1,
        RES_TIMEOUT = 2'd2
    } slot_res_e;

endpackage

// File: rtl/aloha_lfsr.sv
module aloha_lfsr #(
    parameter int W     = 20,
    parameter int TAP_A = 19,
    parameter int TAP_B = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] seed_i,
    input  logic         step_i,
    output logic [W-1:0] value_o
);

    logic [W-1:0] val_d, val_q;
    logic [W-1:0] seed_safe;

    assign seed_safe = (seed_i == '0) ? W'(1) : seed_i;

    always_comb begin
        val_d = val_q;
        if (step_i) begin
            val_d = {val_q[W-2:0], val_q[TAP_A] ^ val_q[TAP_B]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= seed_safe;
        end else begin
            val_q <= val_d;
        end
    end

    assign value_o = val_q;

    // R1: the register never holds the lock-up value
    p_lfsr_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        val_q != '0);

    // R1: without a draw the value holds
    p_lfsr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(val_q));

endmodule

// File: rtl/aloha_slot_ctrl.sv
module aloha_slot_ctrl
    import aloha_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int EXP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic [EXP_W-1:0] frame_log2_i,
    input  logic             slot_adv_i,
    input  logic             ack_i,
    input  logic             nak_i,
    input  logic [CNT_W-1:0] rnd_i,
    output logic             draw_o,
    output logic             tx_now_o,
    output logic             res_valid_o,
    output logic [1:0]       res_code_o
);

    localparam logic [EXP_W-1:0] K_MAX = EXP_W'(CNT_W);

    typedef struct packed {
        slot_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic             tx;
        logic             rv;
        slot_res_e        code;
    } ctrl_t;

    ctrl_t            s_d, s_q;
    logic [EXP_W-1:0] k_eff;
    logic [CNT_W-1:0] slot_mask;
    logic [CNT_W-1:0] slot_pick;
    logic             in_reply;

    assign k_eff     = (frame_log2_i > K_MAX) ? K_MAX : frame_log2_i;
    assign slot_mask = ~({CNT_W{1'b1}} << k_eff);
    assign slot_pick = rnd_i & slot_mask;
    assign draw_o    = frame_start_i && (s_q.st != ST_DONE);
    assign in_reply  = (s_q.st == ST_TXSLOT) || (s_q.st == ST_ACKWIN);

    always_comb begin
        s_d    = s_q;
        s_d.tx = 1'b0;
        s_d.rv = 1'b0;
        if (draw_o) begin
            if (in_reply) begin
                s_d.rv   = 1'b1;
                s_d.code = RES_TIMEOUT;
            end
            s_d.cnt = slot_pick;
            if (slot_pick == '0) begin
                s_d.tx = 1'b1;
                s_d.st = ST_TXSLOT;
            end else begin
                s_d.st = ST_COUNT;
            end
        end else begin
            unique case (s_q.st)
                ST_COUNT: begin
                    if (slot_adv_i) begin
                        s_d.cnt = s_q.cnt - 1'b1;
                        if (s_q.cnt == CNT_W'(1)) begin
                            s_d.tx = 1'b1;
                            s_d.st = ST_TXSLOT;
                        end
                    end
                end
                ST_TXSLOT: begin
                    if (slot_adv_i) s_d.st = ST_ACKWIN;
                end
                ST_ACKWIN: begin
                    if (ack_i) begin
                        s_d.rv   = 1'b1;
                        s_d.code = RES_ACK;
                        s_d.st   = ST_DONE;
                    end else if (nak_i) begin
                        s_d.rv   = 1'b1;
                        s_d.code = RES_NAK;
                        s_d.st   = ST_IDLE;
                    end else if (slot_adv_i) begin
                        s_d.rv   = 1'b1;
                        s_d.code = RES_TIMEOUT;
                        s_d.st   = ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cnt: '0, tx: 1'b0, rv: 1'b0, code: RES_ACK};
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_now_o    = s_q.tx;
    assign res_valid_o = s_q.rv;
    assign res_code_o  = s_q.code;

    // R3: a pending countdown never sits at zero
    p_count_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_COUNT) |-> (s_q.cnt != '0));

    // R3: the count moves only on a slot pulse or a new frame
    p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_COUNT && !slot_adv_i && !frame_start_i) |=> $stable(s_q.cnt));

    // R6: an ACK result only follows the acknowledge slot
    p_ack_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_code_o == 2'd0) |-> ($past(s_q.st) == ST_ACKWIN));

    // R9: an identified tag is silent
    p_done_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DONE && $past(s_q.st) == ST_DONE) |-> (!tx_now_o && !res_valid_o));

    // R8: result codes stay within the defined set
    p_code_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (res_code_o != 2'd3));

endmodule

// File: rtl/aloha_slot_picker.sv
module aloha_slot_picker #(
    parameter int LFSR_W = 20,
    parameter int CNT_W  = 16,
    parameter int EXP_W  = $clog2(CNT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LFSR_W-1:0] seed_i,
    input  logic              frame_start_i,
    input  logic [EXP_W-1:0]  frame_log2_i,
    input  logic              slot_adv_i,
    input  logic              ack_i,
    input  logic              nak_i,
    output logic              tx_now_o,
    output logic              res_valid_o,
    output logic [1:0]        res_code_o
);

    logic [LFSR_W-1:0] rnd_val;
    logic              draw;

    aloha_lfsr #(
        .W     (LFSR_W),
        .TAP_A (LFSR_W - 1),
        .TAP_B (LFSR_W - 4)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed_i  (seed_i),
        .step_i  (draw),
        .value_o (rnd_val)
    );

    aloha_slot_ctrl #(
        .CNT_W (CNT_W),
        .EXP_W (EXP_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start_i),
        .frame_log2_i  (frame_log2_i),
        .slot_adv_i    (slot_adv_i),
        .ack_i         (ack_i),
        .nak_i         (nak_i),
        .rnd_i         (rnd_val[CNT_W-1:0]),
        .draw_o        (draw),
        .tx_now_o      (tx_now_o),
        .res_valid_o   (res_valid_o),
        .res_code_o    (res_code_o)
    );

endmodule

// File: tb/aloha_slot_picker_bench.sv
`timescale 1ns/1ps
module aloha_slot_picker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] seed = '0;
    logic        fs = 0, adv = 0, ack = 0, nak = 0;
    logic [4:0]  kexp = '0;
    logic        tx_now, res_valid;
    logic [1:0]  res_code;

    int          errors = 0;
    int          checks = 0;
    logic [19:0] model;
    logic        o_tx, o_rv;
    logic [1:0]  o_code;
    bit          done = 0;

    always #5 clk = ~clk;

    aloha_slot_picker u_aloha_slot_picker (
        .clk(clk), .rst_n(rst_n), .seed_i(seed), .frame_start_i(fs),
        .frame_log2_i(kexp), .slot_adv_i(adv), .ack_i(ack), .nak_i(nak),
        .tx_now_o(tx_now), .res_valid_o(res_valid), .res_code_o(res_code));

    function automatic logic [19:0] lfsr_next(input logic [19:0] v);
        return {v[18:0], v[19] ^ v[16]};
    endfunction

    function automatic logic [15:0] slot_of(input logic [19:0] v, input int k);
        int kk = (k > 16) ? 16 : k;
        logic [16:0] m = (17'd1 << kk) - 17'd1;
        return v[15:0] & m[15:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit f, input int k, input bit a, input bit ak, input bit nk);
        @(negedge clk);
        fs = f; kexp = 5'(k); adv = a; ack = ak; nak = nk;
        @(posedge clk);
        #1;
        o_tx = tx_now; o_rv = res_valid; o_code = res_code;
        @(negedge clk);
        fs = 0; adv = 0; ack = 0; nak = 0;
    endtask

    task automatic do_reset(input logic [19:0] s);
        @(negedge clk);
        rst_n = 0; seed = s;
        repeat (2) @(negedge clk);
        rst_n = 1;
        model = (s == 0) ? 20'd1 : s;
        #1;
        chk(tx_now == 0 && res_valid == 0, "reset state", int'(tx_now), 0);
    endtask

    // draw a slot, check the immediate strobes, return the slot
    task automatic draw(input int k, input bit pend_to, output int slot);
        slot = int'(slot_of(model, k));
        model = lfsr_next(model);
        cyc(1, k, 0, 0, 0);
        chk(o_tx == (slot == 0), (slot == 0) ? "R4 tx for slot 0" : "R2 no early tx", int'(o_tx), int'(slot == 0));
        chk(o_rv == pend_to, "R11 timeout on restart", int'(o_rv), int'(pend_to));
        if (pend_to) chk(o_code == 2'd2, "R11 restart code", int'(o_code), 2);
    endtask

    // count down from slot s>0 to the transmit strobe
    task automatic countdown(input int s);
        for (int i = 1; i <= s; i++) begin
            cyc(0, 0, 1, 0, 0);
            chk(o_tx == (i == s), "R3 tx after s-th advance", int'(o_tx), int'(i == s));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int  slot, outcome;
        bit  pend;
        void'($urandom(32'd4711));

        // zero seed behaves as seed 1, k above 16 clamps (R1, R2)
        do_reset(20'd0);
        draw(20, 0, slot);
        chk(slot == 1, "R1 zero seed gives 1", slot, 1);
        countdown(slot);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 1);
        chk(o_rv && o_code == 2'd1, "R7 nak result", int'(o_code), 1);

        pend = 0;
        for (int it = 0; it < 60; it++) begin
            int k = $urandom_range(0, 5);
            draw(k, pend, slot);
            pend = 0;
            // R11: interrupt countdown with a new frame
            if (slot >= 2 && $urandom_range(0, 3) == 0) begin
                cyc(0, 0, 1, 0, 0);
                chk(o_tx == 0, "R11 no tx before restart", int'(o_tx), 0);
                draw(k, 0, slot);
            end
            if (slot > 0) countdown(slot);
            // transmit slot: early ack/nak ignored (R6), strobe single (R5)
            cyc(0, 0, 0, $urandom_range(0, 1), $urandom_range(0, 1));
            chk(o_tx == 0, "R5 single tx pulse", int'(o_tx), 0);
            chk(o_rv == 0, "R6 early ack ignored", int'(o_rv), 0);
            cyc(0, 0, 1, 0, 0);
            chk(o_rv == 0, "R6 window opens quietly", int'(o_rv), 0);
            outcome = $urandom_range(0, 3);
            if (outcome == 0) begin
                cyc(0, 0, 0, 1, $urandom_range(0, 1));
                chk(o_rv && o_code == 2'd0, "R6 ack result", int'(o_code), 0);
                // R9: identified tag stays silent
                cyc(1, 0, 0, 0, 0);
                chk(o_tx == 0 && o_rv == 0, "R9 silent after ack", int'(o_tx), 0);
                for (int j = 0; j < 3; j++) begin
                    cyc(0, 0, 1, 1, 0);
                    chk(o_tx == 0 && o_rv == 0, "R9 silent after ack", int'(o_rv), 0);
                end
                do_reset(20'($urandom()));
            end else if (outcome == 1) begin
                cyc(0, 0, 0, 0, 1);
                chk(o_rv && o_code == 2'd1, "R7 nak result", int'(o_code), 1);
            end else if (outcome == 2) begin
                cyc(0, 0, 1, 0, 0);
                chk(o_rv && o_code == 2'd2, "R8 timeout result", int'(o_code), 2);
            end else begin
                pend = 1; // next draw lands in the window (R10, R11)
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule